// File: doc/BRIEF.md
# Multiprocessor Interrupt Router and Level Encoder

This block gathers device interrupt lines and per-processor software and hardware requests for a small multiprocessor system (four CPUs by default) and gives each CPU a 4-bit interrupt level. Level 0 means nothing is pending and level 15 is the most urgent. A shared source mask filters the device lines. The device sources that are active and unmasked are steered to one CPU, which software selects as the routing target. Each device source has a fixed level taken from a constant table.

Software reaches the block through a plain 32-bit register bus with a byte address, separate read and write strobes, write data and registered read data. Each CPU has its own page-sized window. The master window sits on the page after the last CPU window. The set and clear registers are write-only and act only on the bits written as 1. In the master window the mask has inverted sense: writing its clear register enables sources and writing its set register disables them.

Top module: `mpic_top`

## Requirements
- R1: On synchronous reset every source mask bit reads 1 (0xFFFFFFFF), all CPU pending words and the master pending word read 0, the routing target reads 0 and every CPU level output is 0.
- R2: In CPU window c (base c*4096), offset 0 reads the CPU pending word and offset 8 is a write-only set register. Each bit written as 1 sets the matching pending bit. Bits written as 0 leave their pending bits unchanged. Bits 0 and 16 cannot be set and always read 0. A write to offset 0 has no effect.
- R3: CPU window offset 4 is a write-only clear register. Each bit written as 1 clears the matching pending bit, and bits written as 0 have no effect.
- R4: In a CPU pending word, bit x (1..15) is a hardware request at level x and bit 16+x is a software request at level x. The CPU level output becomes the highest pending level one clock after the pending word changes.
- R5: The master window is at base 4*4096. The mask reads at offset 4. Writing 1s to offset 8 clears mask bits, which enables those sources. Writing 1s to offset 12 sets mask bits, which disables those sources.
- R6: Master offset 0 reads the device lines as sampled one clock earlier, at the implemented positions only (bits 7..22 and 28..30), whatever the mask holds. Writes to offset 0 do not change it.
- R7: While mask bit 31 is 1, no device source reaches any CPU, even when its own mask bit is 0.
- R8: An active device source whose mask bit is 0 counts toward the level of the routing target CPU only. Its level is 15 for bits 28..30, 11 for bits 21..22, 9 for bit 20, 10 for bit 19, 4 for bit 18, 13 for bit 17, 6 for bit 16, 12 for bits 14..15, and 2x+1 for expansion level x at bit 7+x.
- R9: Master offset 16 holds the routing target, which can be read and written. A written value of NUM_CPU or above is ignored. A target change moves the device contribution in the next clock.
- R10: Read data appears on the clock edge after the read strobe and holds until the next read. Reads of unmapped offsets or pages return 0, and writes to them change nothing.
- R11: Device sources are level-sensitive. When a line drops, its contribution to the target level is gone two clocks later, with no software action needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_irq | input | 32 | Device interrupt lines, level-sensitive, positions as in R8 |
| cpu_lvl | output | 4*NUM_CPU | Per-CPU interrupt level, CPU c at bits 4c+3..4c |

## Verification
The hardest situation to reach is a contest between a CPU's own pending bits and the routed device level while the routing target and the mask are changing. Reaching it takes a device line held high, the global mask bit cleared after the source bit, and the target moved to a CPU that already has lower-level requests of its own. The stimulus builds this in stages. It raises lines while everything is masked, unmasks the source bit and then bit 31, and moves the target among CPUs that hold their own requests. It then drops lines and exchanges one source for another, checking each intermediate level against the table.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

  localparam int LVL_W = 4;
  localparam int NLVL  = 1 << LVL_W;

  // implemented device positions and storable CPU pending bits
  localparam logic [31:0] DEV_VALID = 32'h707F_FF80;
  localparam logic [31:0] CPU_VALID = 32'hFFFE_FFFE;

  // CPU window offsets
  localparam int CPU_PEND_OFF = 0;
  localparam int CPU_CLR_OFF  = 4;
  localparam int CPU_SET_OFF  = 8;

  // master window offsets
  localparam int MST_PEND_OFF = 0;
  localparam int MST_MASK_OFF = 4;
  localparam int MST_CLR_OFF  = 8;
  localparam int MST_SET_OFF  = 12;
  localparam int MST_TGT_OFF  = 16;

  localparam int GLOBAL_BIT = 31;

  // fixed level for each device source position
  function automatic logic [LVL_W-1:0] src_level(input int b);
    logic [LVL_W-1:0] l;
    if (b >= 28 && b <= 30)    l = 4'd15;
    else if (b >= 7 && b <= 13) l = LVL_W'(2 * (b - 7) + 1);
    else begin
      case (b)
        22, 21:  l = 4'd11;
        20:      l = 4'd9;
        19:      l = 4'd10;
        18:      l = 4'd4;
        17:      l = 4'd13;
        16:      l = 4'd6;
        15, 14:  l = 4'd12;
        default: l = 4'd0;
      endcase
    end
    return l;
  endfunction

endpackage

// File: rtl/mpic_prio_enc.sv
module mpic_prio_enc
  import mpic_pkg::*;
#(
  parameter int N = NLVL
) (
  input  logic [N-1:0]     req,
  output logic [LVL_W-1:0] lvl
);

  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) lvl = LVL_W'(i);
    end
  end

endmodule

// File: rtl/mpic_cpu_slot.sv
module mpic_cpu_slot
  import mpic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [31:0]      wdata,
  input  logic             is_tgt,
  input  logic [NLVL-1:0]  dev_vec,
  output logic [31:0]      pend_q,
  output logic [LVL_W-1:0] lvl_o
);

  logic [NLVL-1:0]  req;
  logic [LVL_W-1:0] lvl_d;
  logic [31:0]      wmask;

  assign wmask = wdata & CPU_VALID;

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= '0;
    else if (set_we) pend_q <= pend_q | wmask;
    else if (clr_we) pend_q <= pend_q & ~wmask;
  end

  // hardware half and software half share the level index
  assign req = pend_q[31:16] | pend_q[15:0] | (is_tgt ? dev_vec : '0);

  mpic_prio_enc #(.N(NLVL)) i_enc (.req(req), .lvl(lvl_d));

  always_ff @(posedge clk) begin
    if (rst) lvl_o <= '0;
    else     lvl_o <= lvl_d;
  end

  // R2: written ones become set
  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((pend_q & $past(wdata & CPU_VALID)) == $past(wdata & CPU_VALID)));
  // R3: written ones become clear
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((pend_q & $past(wdata)) == 32'h0));
  // R2, R3: zero bits have no effect
  a_r2_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (set_we || clr_we) |=> ((pend_q & ~$past(wdata)) == ($past(pend_q) & ~$past(wdata))));
  // R8: a CPU that is not the target with nothing pending stays at level 0
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!is_tgt && pend_q == 32'h0) |=> (lvl_o == '0));

endmodule

// File: rtl/mpic_master.sv
module mpic_master
  import mpic_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      dev_irq,
  input  logic             mclr_we,
  input  logic             mset_we,
  input  logic             tgt_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      dev_q,
  output logic [31:0]      mask_q,
  output logic [TGT_W-1:0] tgt_q,
  output logic [NLVL-1:0]  dev_vec
);

  always_ff @(posedge clk) begin
    if (rst) dev_q <= '0;
    else     dev_q <= dev_irq & DEV_VALID;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (mset_we) mask_q <= mask_q | wdata;
    else if (mclr_we) mask_q <= mask_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) tgt_q <= '0;
    else if (tgt_we && wdata < 32'(NUM_CPU)) tgt_q <= wdata[TGT_W-1:0];
  end

  always_comb begin
    dev_vec = '0;
    for (int b = 0; b < 32; b++) begin
      if (DEV_VALID[b] && dev_q[b] && !mask_q[b] && !mask_q[GLOBAL_BIT])
        dev_vec[src_level(b)] = 1'b1;
    end
  end

  // R5: set register raises mask bits
  a_r5_mask_set: assert property (@(posedge clk) disable iff (rst)
    mset_we |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R5: clear register lowers mask bits
  a_r5_mask_clr: assert property (@(posedge clk) disable iff (rst)
    (mclr_we && !mset_we) |=> ((mask_q & $past(wdata)) == 32'h0));
  // R7: global mask blocks every source
  a_r7_global_block: assert property (@(posedge clk) disable iff (rst)
    mask_q[GLOBAL_BIT] |-> (dev_vec == '0));
  // R9: target always names an existing CPU
  a_r9_tgt_range: assert property (@(posedge clk) disable iff (rst)
    32'(tgt_q) < 32'(NUM_CPU));

endmodule

// File: rtl/mpic_top.sv
module mpic_top
  import mpic_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [31:0]              dev_irq,
  output logic [LVL_W*NUM_CPU-1:0] cpu_lvl
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam logic [PAGE_W-1:0]     MST_PAGE = PAGE_W'(NUM_CPU);
  localparam logic [PAGE_SHIFT-1:0] O_CPEND  = PAGE_SHIFT'(CPU_PEND_OFF);
  localparam logic [PAGE_SHIFT-1:0] O_CCLR   = PAGE_SHIFT'(CPU_CLR_OFF);
  localparam logic [PAGE_SHIFT-1:0] O_CSET   = PAGE_SHIFT'(CPU_SET_OFF);
  localparam logic [PAGE_SHIFT-1:0] O_MPEND  = PAGE_SHIFT'(MST_PEND_OFF);
  localparam logic [PAGE_SHIFT-1:0] O_MMASK  = PAGE_SHIFT'(MST_MASK_OFF);
  localparam logic [PAGE_SHIFT-1:0] O_MCLR   = PAGE_SHIFT'(MST_CLR_OFF);
  localparam logic [PAGE_SHIFT-1:0] O_MSET   = PAGE_SHIFT'(MST_SET_OFF);
  localparam logic [PAGE_SHIFT-1:0] O_MTGT   = PAGE_SHIFT'(MST_TGT_OFF);

  logic [PAGE_W-1:0]     page;
  logic [PAGE_SHIFT-1:0] off;
  logic                  mst_sel;
  logic [31:0]           dev_q, mask_q;
  logic [TGT_W-1:0]      tgt_q;
  logic [NLVL-1:0]       dev_vec;
  logic [31:0]           pend_w [NUM_CPU];
  logic [31:0]           rd_mux;

  assign page    = bus_addr[ADDR_W-1:PAGE_SHIFT];
  assign off     = bus_addr[PAGE_SHIFT-1:0];
  assign mst_sel = (page == MST_PAGE);

  mpic_master #(.NUM_CPU(NUM_CPU)) i_master (
    .clk     (clk),
    .rst     (rst),
    .dev_irq (dev_irq),
    .mclr_we (bus_wr && mst_sel && off == O_MCLR),
    .mset_we (bus_wr && mst_sel && off == O_MSET),
    .tgt_we  (bus_wr && mst_sel && off == O_MTGT),
    .wdata   (bus_wdata),
    .dev_q   (dev_q),
    .mask_q  (mask_q),
    .tgt_q   (tgt_q),
    .dev_vec (dev_vec)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic hit;
    assign hit = (page == PAGE_W'(c));
    mpic_cpu_slot i_slot (
      .clk     (clk),
      .rst     (rst),
      .set_we  (bus_wr && hit && off == O_CSET),
      .clr_we  (bus_wr && hit && off == O_CCLR),
      .wdata   (bus_wdata),
      .is_tgt  (tgt_q == TGT_W'(c)),
      .dev_vec (dev_vec),
      .pend_q  (pend_w[c]),
      .lvl_o   (cpu_lvl[c*LVL_W +: LVL_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (page == PAGE_W'(c) && off == O_CPEND) rd_mux = pend_w[c];
    end
    if (mst_sel) begin
      case (off)
        O_MPEND: rd_mux = dev_q;
        O_MMASK: rd_mux = mask_q;
        O_MTGT:  rd_mux = 32'(tgt_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R10: read data holds between reads
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R6: pending never shows unimplemented positions
  a_r6_pend_valid: assert property (@(posedge clk) disable iff (rst)
    (dev_q & ~DEV_VALID) == 32'h0);

endmodule

// File: tb/test_mpic_top.sv
module test_mpic_top;
  localparam int NUM_CPU = 4;
  localparam logic [15:0] M = 16'h4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] dev_irq = '0;
  logic [4*NUM_CPU-1:0] cpu_lvl;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mpic_top #(.NUM_CPU(NUM_CPU)) i_mpic_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev_irq), .cpu_lvl(cpu_lvl)
  );

  // monitor: compares due items
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      got = (it.kind == 0) ? bus_rdata : {28'h0, cpu_lvl[it.idx*4 +: 4]};
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.tag, it.kind, it.idx, got, it.exp);
      end
    end
  end

  task automatic push(input int kind, input int idx, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.due = cyc + 1; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    idle();
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [15:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    push(0, 0, exp, tag);
    idle();
    bus_rd = 1'b0;
  endtask

  task automatic lvl_exp(input int l0, input int l1, input int l2, input int l3, input string tag);
    push(1, 0, 32'(l0), tag);
    push(1, 1, 32'(l1), tag);
    push(1, 2, 32'(l2), tag);
    push(1, 3, 32'(l3), tag);
    idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd_exp(M + 16'd4,  32'hFFFF_FFFF, "R1 mask");
    rd_exp(M + 16'd16, 32'h0, "R1 target");
    rd_exp(16'h0000,   32'h0, "R1 cpu0 pending");
    rd_exp(M,          32'h0, "R1 master pending");
    lvl_exp(0, 0, 0, 0, "R1 levels");

    // R2 set register, bit 0 not storable
    wr(16'h1008, 32'h0000_0021);
    rd_exp(16'h1000, 32'h0000_0020, "R2 set with bit0");
    lvl_exp(0, 5, 0, 0, "R4 hw level 5");
    wr(16'h1008, 32'h0008_0000);
    rd_exp(16'h1000, 32'h0008_0020, "R2 zero bits keep");
    lvl_exp(0, 5, 0, 0, "R4 higher hw wins");

    // R3 clear register
    wr(16'h1004, 32'h0000_0020);
    rd_exp(16'h1000, 32'h0008_0000, "R3 clear one bit");
    lvl_exp(0, 3, 0, 0, "R4 soft level 3");
    wr(16'h1004, 32'h0);
    rd_exp(16'h1000, 32'h0008_0000, "R3 zero clear no effect");
    wr(16'h1008, 32'h0001_0001);
    rd_exp(16'h1000, 32'h0008_0000, "R2 bits 0 and 16 not stored");

    // R4 top level and fall back
    wr(16'h2008, 32'h8000_0004);
    lvl_exp(0, 3, 15, 0, "R4 soft 15");
    wr(16'h2004, 32'h8000_0000);
    lvl_exp(0, 3, 2, 0, "R4 back to hw 2");

    // R6 R7 device lines while masked
    dev_irq = (32'h1 << 19) | 32'h3;
    idle();
    rd_exp(M, 32'h0008_0000, "R6 pending implemented bits only");
    lvl_exp(0, 3, 2, 0, "R7 all masked");

    // R5 unmask source, global still set
    wr(M + 16'd8, 32'h0008_0000);
    rd_exp(M + 16'd4, 32'hFFF7_FFFF, "R5 clear mask bit");
    lvl_exp(0, 3, 2, 0, "R7 global bit blocks");
    wr(M + 16'd8, 32'h8000_0000);
    rd_exp(M + 16'd4, 32'h7FF7_FFFF, "R5 clear global bit");
    lvl_exp(10, 3, 2, 0, "R8 timer to target 0");

    // R9 routing target
    wr(M + 16'd16, 32'd1);
    rd_exp(M + 16'd16, 32'd1, "R9 target readback");
    lvl_exp(0, 10, 2, 0, "R9 moved to cpu1");
    wr(M + 16'd16, 32'd7);
    rd_exp(M + 16'd16, 32'd1, "R9 out of range ignored");
    wr(M + 16'd16, 32'd2);
    lvl_exp(0, 3, 10, 0, "R9 moved to cpu2");
    wr(M + 16'd16, 32'd1);

    // R8 serial then remask
    wr(M + 16'd8, 32'h0000_8000);
    dev_irq = (32'h1 << 19) | (32'h1 << 15);
    idle();
    lvl_exp(0, 12, 2, 0, "R8 serial level 12");
    wr(M + 16'd12, 32'h0000_8000);
    rd_exp(M + 16'd4, 32'h7FF7_FFFF, "R5 set mask bit");
    lvl_exp(0, 10, 2, 0, "R5 serial disabled");

    // R11 line drop, expansion level
    wr(M + 16'd8, 32'h0000_0200);
    dev_irq = (32'h1 << 9) | (32'h1 << 15);
    idle();
    lvl_exp(0, 5, 2, 0, "R11 timer dropped expansion 5");

    // R6 masked source still visible, error level
    wr(M + 16'd8, 32'h2000_0000);
    dev_irq = (32'h1 << 9) | (32'h1 << 29) | (32'h1 << 30);
    idle();
    rd_exp(M, 32'h6000_0200, "R6 pending ignores mask");
    lvl_exp(0, 15, 2, 0, "R8 error level 15");

    // R10 unmapped and read-only targets
    rd_exp(M + 16'h20, 32'h0, "R10 unmapped offset");
    rd_exp(16'h5000,   32'h0, "R10 unmapped page");
    wr(M, 32'hFFFF_FFFF);
    rd_exp(M, 32'h6000_0200, "R6 pending write ignored");
    wr(16'h3000, 32'hFFFF_FFFF);
    rd_exp(16'h3000, 32'h0, "R2 pending offset write ignored");
    wr(16'h5008, 32'hFFFF_FFFF);
    rd_exp(M + 16'd4, 32'h5FF7_FDFF, "R10 unmapped write ignored");
    lvl_exp(0, 15, 2, 0, "R10 levels unchanged");

    // R7 global mask again
    wr(M + 16'd12, 32'h8000_0000);
    lvl_exp(0, 3, 2, 0, "R7 global set blocks");

    // R1 reset again
    @(negedge clk) rst = 1'b1;
    idle(); idle();
    rst = 1'b0;
    rd_exp(M + 16'd4, 32'hFFFF_FFFF, "R1 mask after reset");
    rd_exp(16'h1000, 32'h0, "R1 pending after reset");
    lvl_exp(0, 0, 0, 0, "R1 levels after reset");

    idle();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule